// File: doc/BRIEF.md
# Inter-Socket Snoop Policy Controller

This controller sits at the home agent of one socket in a multi-socket system and handles one miss transaction at a time. A miss request arrives with the id of the socket that missed in its shared cache and a read or read-for-ownership flag. The controller always starts a memory read. It decides, from a static mode setting, the socket count and the link load, whether the other sockets are snooped in parallel with that read, after it, or not at all. It reports completion once the data is known to be valid, with a tag that says where the valid data came from.

There are three modes. Parallel mode (code 0) snoops at once. Deferred mode (code 1, and also the unused code 3) waits for the memory read and its per-line directory bit before it snoops. Adaptive mode (code 2) picks parallel behaviour when the link is idle and deferred behaviour when the link is busy, judged at the moment the request is accepted. Snoop targets are sent as one command that carries a bitmask of sockets, and each target returns one acknowledgement. An acknowledgement may carry a dirty flag, and its data then replaces the memory data.

Top module: `snoop_policy_ctrl`

## Requirements
- R1: After reset, mem_rd_o, snp_valid_o and done_o are low, snp_mask_o is zero and done_src_o is zero.
- R2: A request seen on req_valid_i while the controller is idle is accepted. mem_rd_o is high for exactly one cycle, the cycle after acceptance.
- R3: The snoop target mask has bit i set exactly when socket i exists (i < 2 when cfg_four_skt_i is 0, i < 4 when it is 1), socket i is not cfg_home_id_i and socket i is not req_src_i.
- R4: In parallel mode (cfg_mode_i = 0), snp_valid_o pulses for one cycle together with mem_rd_o and carries the full target mask. When the mask is empty, no snoop is sent.
- R5: In deferred mode (cfg_mode_i = 1 or 3), no snoop is sent before the memory read returns (mem_done_i). For a read with mem_dir_i = 0, no snoop is sent at all. For a read with mem_dir_i = 1, the target mask is snooped in the cycle after mem_done_i is sampled.
- R6: In adaptive mode (cfg_mode_i = 2), link_busy_i = 1 at acceptance gives the behaviour of R5, and link_busy_i = 0 gives the behaviour of R4.
- R7: On a deferred path, a read-for-ownership (req_rfo_i = 1) snoops the full target mask whatever mem_dir_i says.
- R8: done_o is a single-cycle pulse. It rises in the cycle after the later of the memory return and the last acknowledgement from the target mask, and never earlier.
- R9: done_src_o is 3'b000 when memory data is final. When a target acknowledged with snp_rsp_dirty_i = 1, it is {1'b1, socket id}. It is zero whenever done_o is low.
- R10: A request presented while a transaction is in progress is ignored: it produces no mem_rd_o and no snoop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_mode_i | input | 2 | Snoop mode: 0 parallel, 1/3 deferred, 2 adaptive |
| cfg_four_skt_i | input | 1 | 0: two sockets, 1: four sockets |
| cfg_home_id_i | input | 2 | Id of this (home) socket |
| link_busy_i | input | 1 | Inter-socket link load is high |
| req_valid_i | input | 1 | Miss request strobe |
| req_rfo_i | input | 1 | Request is a read-for-ownership |
| req_src_i | input | 2 | Id of the requesting socket |
| mem_rd_o | output | 1 | Memory read command pulse |
| mem_done_i | input | 1 | Memory read data returned |
| mem_dir_i | input | 1 | Directory bit with mem_done_i: a remote dirty copy is possible |
| snp_valid_o | output | 1 | Remote snoop command pulse |
| snp_mask_o | output | 4 | Target sockets of the snoop |
| snp_rsp_valid_i | input | 1 | Snoop acknowledgement strobe |
| snp_rsp_src_i | input | 2 | Socket that acknowledges |
| snp_rsp_dirty_i | input | 1 | Acknowledgement carries dirty data |
| done_o | output | 1 | Transaction complete pulse |
| done_src_o | output | 3 | Data source tag |

## Verification
Every output is registered, so each result is due exactly one cycle after the edge that samples its cause. mem_rd_o and a parallel snoop follow the accepting edge. A deferred snoop follows the edge that samples mem_dir_i. done_o follows the edge that samples the last outstanding event. The bench drives stimulus on falling edges and samples on the falling edge that follows the sampling rising edge. It also checks that done_o is low one cycle earlier and low again one cycle later, which pins both the time of the pulse and its width.

// File: rtl/snp_pol_pkg.sv
package snp_pol_pkg;
  typedef enum logic [1:0] {
    MODE_PARALLEL = 2'd0,
    MODE_DEFERRED = 2'd1,
    MODE_ADAPTIVE = 2'd2,
    MODE_RSVD     = 2'd3
  } snp_mode_e;
endpackage

// File: rtl/snp_target_calc.sv
module snp_target_calc #(
  parameter int NUM_SKT = 4,
  localparam int SKT_W  = $clog2(NUM_SKT)
) (
  input  logic               four_skt_i,
  input  logic [SKT_W-1:0]   home_id_i,
  input  logic [SKT_W-1:0]   src_id_i,
  output logic [NUM_SKT-1:0] mask_o
);
  localparam int SMALL_CNT = 2;

  for (genvar g = 0; g < NUM_SKT; g++) begin : g_skt
    logic present;
    assign present   = (g < SMALL_CNT) || four_skt_i;
    assign mask_o[g] = present && (home_id_i != SKT_W'(g)) && (src_id_i != SKT_W'(g));
  end
endmodule

// File: rtl/snp_path_sel.sv
module snp_path_sel
  import snp_pol_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       link_busy_i,
  output logic       parallel_o
);
  always_comb begin
    unique case (snp_mode_e'(mode_i))
      MODE_PARALLEL: parallel_o = 1'b1;
      MODE_ADAPTIVE: parallel_o = !link_busy_i;
      default:       parallel_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/snp_ack_tracker.sv
module snp_ack_tracker #(
  parameter int NUM_SKT = 4,
  localparam int SKT_W  = $clog2(NUM_SKT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               load_i,
  input  logic [NUM_SKT-1:0] load_mask_i,
  input  logic               rsp_valid_i,
  input  logic [SKT_W-1:0]   rsp_src_i,
  input  logic               rsp_dirty_i,
  output logic [NUM_SKT-1:0] pend_nxt_o,
  output logic               dirty_nxt_o,
  output logic [SKT_W-1:0]   dirty_src_nxt_o
);
  logic [NUM_SKT-1:0] pend_q, hit;
  logic               dirty_q, take_dirty;
  logic [SKT_W-1:0]   dirty_src_q;

  // only acks from sockets still pending count
  assign hit        = rsp_valid_i ? (pend_q & (NUM_SKT'(1) << rsp_src_i)) : '0;
  assign take_dirty = (|hit) && rsp_dirty_i;

  assign pend_nxt_o      = load_i ? load_mask_i : (clear_i ? '0 : (pend_q & ~hit));
  assign dirty_nxt_o     = clear_i ? 1'b0 : (dirty_q | take_dirty);
  assign dirty_src_nxt_o = take_dirty ? rsp_src_i : dirty_src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= '0;
      dirty_q     <= 1'b0;
      dirty_src_q <= '0;
    end else begin
      pend_q      <= pend_nxt_o;
      dirty_q     <= dirty_nxt_o;
      dirty_src_q <= clear_i ? '0 : dirty_src_nxt_o;
    end
  end
endmodule

// File: rtl/snoop_policy_ctrl.sv
module snoop_policy_ctrl #(
  parameter int NUM_SKT = 4,
  localparam int SKT_W  = $clog2(NUM_SKT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         cfg_mode_i,
  input  logic               cfg_four_skt_i,
  input  logic [SKT_W-1:0]   cfg_home_id_i,
  input  logic               link_busy_i,
  input  logic               req_valid_i,
  input  logic               req_rfo_i,
  input  logic [SKT_W-1:0]   req_src_i,
  output logic               mem_rd_o,
  input  logic               mem_done_i,
  input  logic               mem_dir_i,
  output logic               snp_valid_o,
  output logic [NUM_SKT-1:0] snp_mask_o,
  input  logic               snp_rsp_valid_i,
  input  logic [SKT_W-1:0]   snp_rsp_src_i,
  input  logic               snp_rsp_dirty_i,
  output logic               done_o,
  output logic [SKT_W:0]     done_src_o
);
  logic               busy_q, mem_pend_q, defer_q, rfo_q;
  logic [NUM_SKT-1:0] cand_q, cand;
  logic               mem_rd_q, snp_v_q, done_q;
  logic [NUM_SKT-1:0] snp_mask_q;
  logic [SKT_W:0]     done_src_q;

  logic               accept, parallel, mem_ret, issue_def, load, finish, mem_pend_nxt;
  logic [NUM_SKT-1:0] load_mask, pend_nxt;
  logic               dirty_nxt;
  logic [SKT_W-1:0]   dirty_src_nxt;

  snp_target_calc #(.NUM_SKT(NUM_SKT)) u_target (
    .four_skt_i (cfg_four_skt_i),
    .home_id_i  (cfg_home_id_i),
    .src_id_i   (req_src_i),
    .mask_o     (cand)
  );

  snp_path_sel u_path (
    .mode_i      (cfg_mode_i),
    .link_busy_i (link_busy_i),
    .parallel_o  (parallel)
  );

  assign accept       = req_valid_i && !busy_q;
  assign mem_ret      = busy_q && mem_pend_q && mem_done_i;
  assign mem_pend_nxt = mem_pend_q && !mem_done_i;
  // deferred path: snoop only if ownership wanted or directory flags a remote dirty copy
  assign issue_def    = mem_ret && defer_q && (rfo_q || mem_dir_i) && (|cand_q);
  assign load         = (accept && parallel && (|cand)) || issue_def;
  assign load_mask    = accept ? cand : cand_q;

  snp_ack_tracker #(.NUM_SKT(NUM_SKT)) u_ack (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .clear_i         (accept),
    .load_i          (load),
    .load_mask_i     (load_mask),
    .rsp_valid_i     (snp_rsp_valid_i),
    .rsp_src_i       (snp_rsp_src_i),
    .rsp_dirty_i     (snp_rsp_dirty_i),
    .pend_nxt_o      (pend_nxt),
    .dirty_nxt_o     (dirty_nxt),
    .dirty_src_nxt_o (dirty_src_nxt)
  );

  assign finish = busy_q && !mem_pend_nxt && !issue_def && !(|pend_nxt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      mem_pend_q <= 1'b0;
      defer_q    <= 1'b0;
      rfo_q      <= 1'b0;
      cand_q     <= '0;
    end else if (accept) begin
      busy_q     <= 1'b1;
      mem_pend_q <= 1'b1;
      defer_q    <= !parallel;
      rfo_q      <= req_rfo_i;
      cand_q     <= cand;
    end else begin
      mem_pend_q <= mem_pend_nxt;
      if (mem_ret) defer_q <= 1'b0;
      if (finish)  busy_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_rd_q   <= 1'b0;
      snp_v_q    <= 1'b0;
      snp_mask_q <= '0;
      done_q     <= 1'b0;
      done_src_q <= '0;
    end else begin
      mem_rd_q   <= accept;
      snp_v_q    <= load;
      snp_mask_q <= load ? load_mask : '0;
      done_q     <= finish;
      done_src_q <= (finish && dirty_nxt) ? {1'b1, dirty_src_nxt} : '0;
    end
  end

  assign mem_rd_o    = mem_rd_q;
  assign snp_valid_o = snp_v_q;
  assign snp_mask_o  = snp_mask_q;
  assign done_o      = done_q;
  assign done_src_o  = done_src_q;
endmodule

// File: rtl/snp_pol_chk.sv
module snp_pol_chk #(
  parameter int NUM_SKT = 4,
  localparam int SKT_W  = $clog2(NUM_SKT)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [1:0]         cfg_mode_i,
  input logic               cfg_four_skt_i,
  input logic [SKT_W-1:0]   cfg_home_id_i,
  input logic               req_valid_i,
  input logic               mem_rd_o,
  input logic               mem_done_i,
  input logic               snp_valid_o,
  input logic [NUM_SKT-1:0] snp_mask_o,
  input logic               done_o,
  input logic [SKT_W:0]     done_src_o
);
  assert_mem_rd_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);
  assert_mem_rd_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> $past(req_valid_i));
  assert_no_home_snoop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_o |-> !snp_mask_o[cfg_home_id_i]);
  assert_two_skt_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_o && !cfg_four_skt_i) |-> ((snp_mask_o >> 2) == '0));
  assert_snoop_nonempty_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_o |-> (|snp_mask_o));
  assert_parallel_with_rd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_o && cfg_mode_i == 2'd0) |-> mem_rd_o);
  assert_deferred_after_mem_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_o && cfg_mode_i == 2'd1) |-> $past(mem_done_i));
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_src_only_on_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (done_src_o == '0));
endmodule

bind snoop_policy_ctrl snp_pol_chk #(.NUM_SKT(NUM_SKT)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cfg_mode_i     (cfg_mode_i),
  .cfg_four_skt_i (cfg_four_skt_i),
  .cfg_home_id_i  (cfg_home_id_i),
  .req_valid_i    (req_valid_i),
  .mem_rd_o       (mem_rd_o),
  .mem_done_i     (mem_done_i),
  .snp_valid_o    (snp_valid_o),
  .snp_mask_o     (snp_mask_o),
  .done_o         (done_o),
  .done_src_o     (done_src_o)
);

// File: tb/snoop_policy_ctrl_test.sv
`timescale 1ns/1ps
module snoop_policy_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_mode = '0;
  logic       cfg_four = 1'b0;
  logic [1:0] cfg_home = '0;
  logic       link_busy = 1'b0;
  logic       req_valid = 1'b0, req_rfo = 1'b0;
  logic [1:0] req_src = '0;
  logic       mem_rd, mem_done = 1'b0, mem_dir = 1'b0;
  logic       snp_valid;
  logic [3:0] snp_mask;
  logic       rsp_valid = 1'b0, rsp_dirty = 1'b0;
  logic [1:0] rsp_src = '0;
  logic       done;
  logic [2:0] done_src;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  snoop_policy_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_mode_i(cfg_mode), .cfg_four_skt_i(cfg_four),
    .cfg_home_id_i(cfg_home), .link_busy_i(link_busy), .req_valid_i(req_valid),
    .req_rfo_i(req_rfo), .req_src_i(req_src), .mem_rd_o(mem_rd), .mem_done_i(mem_done),
    .mem_dir_i(mem_dir), .snp_valid_o(snp_valid), .snp_mask_o(snp_mask),
    .snp_rsp_valid_i(rsp_valid), .snp_rsp_src_i(rsp_src), .snp_rsp_dirty_i(rsp_dirty),
    .done_o(done), .done_src_o(done_src)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int targets(input bit four, input int home, input int src);
    int m = 0;
    for (int i = 0; i < 4; i++)
      if ((i < (four ? 4 : 2)) && i != home && i != src) m |= (1 << i);
    return m;
  endfunction

  // one full transaction, memory returns one cycle after acceptance, acks follow
  task automatic run_txn(input string tag, input int mode, input bit four, input int home,
                         input int src, input bit rfo, input bit busy, input bit dir,
                         input int dirty_id);
    int  mask, left, exp_src;
    bit  par, early_snp, late_snp;
    mask      = targets(four, home, src);
    par       = (mode == 0) || (mode == 2 && !busy);
    early_snp = par && (mask != 0);
    late_snp  = !par && (rfo || dir) && (mask != 0);
    exp_src   = (dirty_id >= 0) ? (4 | dirty_id) : 0;

    @(negedge clk);
    cfg_mode = 2'(mode); cfg_four = four; cfg_home = 2'(home);
    link_busy = busy; req_valid = 1'b1; req_rfo = rfo; req_src = 2'(src);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    check(mem_rd == 1'b1, {tag, " R2 mem_rd after accept"}, mem_rd, 1);
    check(snp_valid == early_snp, {tag, " R4/R6 early snoop"}, snp_valid, early_snp);
    if (early_snp) check(snp_mask == 4'(mask), {tag, " R3 early mask"}, snp_mask, mask);
    mem_done = 1'b1; mem_dir = dir;
    @(posedge clk); @(negedge clk);
    mem_done = 1'b0; mem_dir = 1'b0;
    check(mem_rd == 1'b0, {tag, " R2 mem_rd single pulse"}, mem_rd, 0);
    check(snp_valid == late_snp, {tag, " R5/R7 deferred snoop"}, snp_valid, late_snp);
    if (late_snp) check(snp_mask == 4'(mask), {tag, " R3 deferred mask"}, snp_mask, mask);
    if (!early_snp && !late_snp) begin
      check(done && done_src == 3'(exp_src), {tag, " R8/R9 done from memory"},
            {done, done_src}, {1'b1, 3'(exp_src)});
    end else begin
      check(done == 1'b0, {tag, " R8 no done while acks pending"}, done, 0);
      left = $countones(mask);
      for (int i = 0; i < 4; i++) begin
        if (mask[i]) begin
          rsp_valid = 1'b1; rsp_src = 2'(i); rsp_dirty = (i == dirty_id);
          @(posedge clk); @(negedge clk);
          rsp_valid = 1'b0; rsp_dirty = 1'b0;
          left--;
          if (left > 0) check(done == 1'b0, {tag, " R8 done before last ack"}, done, 0);
          else check(done && done_src == 3'(exp_src), {tag, " R8/R9 done after last ack"},
                     {done, done_src}, {1'b1, 3'(exp_src)});
        end
      end
    end
    @(negedge clk);
    check(done == 1'b0, {tag, " R8 done single pulse"}, done, 0);
  endtask

  task automatic t_reset();
    check(!mem_rd && !snp_valid && !done && snp_mask == 0 && done_src == 0,
          "R1 reset outputs", {mem_rd, snp_valid, done, snp_mask, done_src}, 0);
  endtask

  task automatic t_parallel_two_local();
    run_txn("par2_local", 0, 1'b0, 0, 0, 1'b0, 1'b0, 1'b0, -1);
  endtask

  task automatic t_parallel_two_remote();
    run_txn("par2_remote", 0, 1'b0, 0, 1, 1'b0, 1'b0, 1'b1, -1);
  endtask

  task automatic t_parallel_four_dirty();
    run_txn("par4_dirty", 0, 1'b1, 1, 1, 1'b0, 1'b0, 1'b0, 3);
  endtask

  task automatic t_deferred_clean();
    run_txn("def_clean", 1, 1'b1, 2, 0, 1'b0, 1'b0, 1'b0, -1);
  endtask

  task automatic t_deferred_dirty();
    run_txn("def_dirty", 1, 1'b1, 2, 0, 1'b0, 1'b0, 1'b1, 1);
  endtask

  task automatic t_adaptive_busy_clean();
    run_txn("adp_busy", 2, 1'b1, 0, 0, 1'b0, 1'b1, 1'b0, -1);
  endtask

  task automatic t_adaptive_idle();
    run_txn("adp_idle", 2, 1'b1, 0, 0, 1'b0, 1'b0, 1'b0, 2);
  endtask

  task automatic t_adaptive_busy_rfo();
    run_txn("adp_rfo", 2, 1'b1, 3, 1, 1'b1, 1'b1, 1'b0, -1);
  endtask

  task automatic t_deferred_two_rfo();
    run_txn("def2_rfo", 1, 1'b0, 0, 1, 1'b1, 1'b0, 1'b1, -1);
  endtask

  task automatic t_busy_ignore();
    @(negedge clk);
    cfg_mode = 2'd0; cfg_four = 1'b0; cfg_home = 2'd0; link_busy = 1'b0;
    req_valid = 1'b1; req_rfo = 1'b0; req_src = 2'd0;
    @(posedge clk); @(negedge clk);
    req_src = 2'd2; cfg_four = 1'b1;           // second request held while busy
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; cfg_four = 1'b0; req_src = 2'd0;
    check(mem_rd == 1'b0 && snp_valid == 1'b0, "R10 busy request ignored",
          {mem_rd, snp_valid}, 0);
    mem_done = 1'b1;
    @(posedge clk); @(negedge clk);
    mem_done = 1'b0;
    check(mem_rd == 1'b0 && snp_valid == 1'b0 && done == 1'b0, "R10 no second transaction",
          {mem_rd, snp_valid, done}, 0);
    rsp_valid = 1'b1; rsp_src = 2'd1;
    @(posedge clk); @(negedge clk);
    rsp_valid = 1'b0;
    check(done == 1'b1 && done_src == 3'd0, "R10 first transaction completes",
          {done, done_src}, 8);
    @(negedge clk); @(negedge clk);
    check(mem_rd == 1'b0 && done == 1'b0, "R10 nothing after completion", {mem_rd, done}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_parallel_two_local();
    t_parallel_two_remote();
    t_parallel_four_dirty();
    t_deferred_clean();
    t_deferred_dirty();
    t_adaptive_busy_clean();
    t_adaptive_idle();
    t_adaptive_busy_rfo();
    t_deferred_two_rfo();
    t_busy_ignore();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule